// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock from the kernel clock. A programmable divider field sets the half-period in kernel cycles, so the card clock runs at the kernel rate divided by twice the field. A zero field selects a pass-through of the kernel clock. Pass-through is refused when double-data-rate timing is selected; the block then divides by two instead. Requests larger than the field can hold saturate to its largest value. That largest value is also the slowest rate available, and it is the rate used while the card powers up.

Next to the clock the block produces a one-kernel-cycle sample strobe. Logic in the kernel domain uses it to act once per card-clock rising edge. An enable input stops the clock low for the power-off and power-cycle states. While the enable is low the block reloads its configuration on every cycle. When the clock runs, a new divider is taken only at the end of a low phase, so every started phase completes at the old length.

Top module: `sdclk_gen`

## Requirements
- R1: With an effective divider N of 1 or more, the card clock is high for exactly N kernel cycles and then low for exactly N kernel cycles, which gives a period of 2N and a 50 percent duty cycle.
- R2: A zero divider request with DDR mode low selects bypass. After the configuration settles, the card clock follows the kernel clock: it is high while the kernel clock is high and low while it is low. The sample strobe is then held high.
- R3: A zero divider request with DDR mode high does not bypass. The effective divider becomes 1, so the card clock is half the kernel clock.
- R4: A request above the largest field value 2^DIV_W-1 saturates to that value. A request between 1 and 2^DIV_W-1 is used as it is.
- R5: A divider change made while the clock runs is taken only at the end of a low phase. The phases already running finish with the old divider, and the first high phase after the change uses the new one.
- R6: While the enable is low the card clock is low from the next kernel edge and the strobe is low. After the enable rises, with the divider resolved to N, the first rising edge of the card clock comes at the Nth kernel edge.
- R7: In divided mode the sample strobe is high for exactly one kernel cycle, the cycle that starts at each rising edge of the card clock, and is low otherwise.
- R8: During and right after reset the card clock and the strobe are low. Reset loads the largest divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Run the card clock; low holds it stopped low |
| ddrMode | input | 1 | Double-data-rate timing; forbids bypass |
| divReq | input | REQ_W | Requested divider field |
| cardClk | output | 1 | Card clock |
| sampleStb | output | 1 | One-cycle strobe at each card-clock rise |

## Verification
The bench builds the block with DIV_W=3 and REQ_W=5. This gives a field maximum of 7 and a request range of 0 to 31. With these values it can sweep every request value with DDR mode both low and high. The sweep covers bypass, the forced divide-by-two, every legal divider and every saturating request, and it checks the whole waveform cycle by cycle over two periods. Directed cases then change the divider in the middle of a high phase, stop the clock with the enable, and check the reset state.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  typedef struct packed {
    logic run;     // divided mode active
    logic toggle;  // invert the divided level at this edge
    logic bypass;  // pass kernel clock through
  } sdclk_cmd_t;
endpackage

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int REQ_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             ddrMode,
  input  logic [REQ_W-1:0] divReq,
  input  logic             divLevel,
  output sdclk_cmd_t       cmd
);
  localparam int DIV_MAX = (1 << DIV_W) - 1;
  localparam logic [DIV_W-1:0] MAX_VAL = DIV_W'(DIV_MAX);

  logic [DIV_W-1:0] reqSat, nextDiv, activeDiv, cnt;
  logic             nextByp, activeByp, lastTick, loadNow;

  // resolve request: saturate, then zero -> bypass or divide-by-1
  always_comb begin
    reqSat  = (divReq > REQ_W'(DIV_MAX)) ? MAX_VAL : divReq[DIV_W-1:0];
    nextByp = (reqSat == '0) && !ddrMode;
    nextDiv = (reqSat == '0) ? DIV_W'(1) : reqSat;
  end

  assign lastTick = (cnt == activeDiv - DIV_W'(1));
  assign loadNow  = !clkEn || activeByp || (lastTick && !divLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeDiv <= MAX_VAL;
      activeByp <= 1'b0;
      cnt       <= '0;
    end else begin
      if (loadNow) begin
        activeDiv <= nextDiv;
        activeByp <= nextByp;
      end
      if (!clkEn || activeByp || lastTick) cnt <= '0;
      else                                 cnt <= cnt + DIV_W'(1);
    end
  end

  always_comb begin
    cmd.run    = clkEn && !activeByp;
    cmd.toggle = clkEn && !activeByp && lastTick;
    cmd.bypass = clkEn && activeByp;
  end

  // R1
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeByp |-> (cnt < activeDiv));
  // R4
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeDiv != '0);
  // R5
  reload_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(clkEn) && !$past(activeByp) && (activeDiv != $past(activeDiv)))
      |-> !$past(divLevel));
  // R6
  stop_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> !divLevel);
endmodule

// File: rtl/sdclk_dp.sv
module sdclk_dp
  import sdclk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  sdclk_cmd_t cmd,
  output logic       divLevel,
  output logic       cardClk,
  output logic       sampleStb
);
  logic riseStb, bypOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLevel <= 1'b0;
      riseStb  <= 1'b0;
      bypOut   <= 1'b0;
    end else begin
      bypOut <= cmd.bypass;
      if (!cmd.run) begin
        divLevel <= 1'b0;
        riseStb  <= 1'b0;
      end else begin
        if (cmd.toggle) divLevel <= !divLevel;
        riseStb <= cmd.toggle && !divLevel;
      end
    end
  end

  assign cardClk   = bypOut ? clk : divLevel;
  assign sampleStb = bypOut | riseStb;

  // R7
  stb_on_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> divLevel);
  // R7
  stb_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |=> !riseStb);
  // R2
  byp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    bypOut |-> !divLevel);
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
  import sdclk_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int REQ_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             ddrMode,
  input  logic [REQ_W-1:0] divReq,
  output logic             cardClk,
  output logic             sampleStb
);
  sdclk_cmd_t cmd;
  logic       divLevel;

  sdclk_ctrl #(.DIV_W(DIV_W), .REQ_W(REQ_W)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .ddrMode(ddrMode),
    .divReq(divReq), .divLevel(divLevel), .cmd(cmd)
  );

  sdclk_dp uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .divLevel(divLevel),
    .cardClk(cardClk), .sampleStb(sampleStb)
  );
endmodule

// File: tb/tb_sdclk_gen.sv
module tb_sdclk_gen;
  localparam int DW = 3;
  localparam int RW = 5;
  localparam int MAXD = (1 << DW) - 1;

  logic clk = 1'b0, rstN = 1'b0, clkEn = 1'b0, ddrMode = 1'b0;
  logic [RW-1:0] divReq = '0;
  logic cardClk, sampleStb;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdclk_gen #(.DIV_W(DW), .REQ_W(RW)) dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .ddrMode(ddrMode),
    .divReq(divReq), .cardClk(cardClk), .sampleStb(sampleStb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // stop, configure, then start; returns at the negedge before E0
  task automatic startCfg(input int req, input bit ddr);
    @(negedge clk);
    clkEn = 1'b0; divReq = RW'(req); ddrMode = ddr;
    repeat (3) @(negedge clk);
    clkEn = 1'b1;
  endtask

  initial begin
    #50000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (3) @(negedge clk);
    chk(cardClk == 1'b0, "R8 clk in reset", cardClk, 0);
    chk(sampleStb == 1'b0, "R8 stb in reset", sampleStb, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(cardClk == 1'b0, "R8 clk after reset", cardClk, 0);
    chk(sampleStb == 1'b0, "R8 stb after reset", sampleStb, 0);

    // full sweep: R1 R2 R3 R4 R6 R7
    for (int r = 0; r < (1 << RW); r++) begin
      for (int d = 0; d < 2; d++) begin
        int sat, n;
        sat = (r > MAXD) ? MAXD : r;
        startCfg(r, d[0]);
        if (sat == 0 && d == 0) begin
          repeat (3) @(negedge clk);
          for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1;
            chk(cardClk == 1'b1, "R2 bypass high", cardClk, 1);
            chk(sampleStb == 1'b1, "R2 bypass stb", sampleStb, 1);
            @(negedge clk); #1;
            chk(cardClk == 1'b0, "R2 bypass low", cardClk, 0);
          end
        end else begin
          n = (sat == 0) ? 1 : sat;  // R3 ddr zero -> 1, R4 saturation
          for (int k = 0; k < 4 * n; k++) begin
            int tg;
            @(negedge clk);
            tg = (k + 1) / n;
            chk(cardClk == tg[0], (sat == 0) ? "R3 ddr div1 level" :
                (r > MAXD ? "R4 saturated level" : "R1 divided level"),
                cardClk, tg % 2);
            chk(sampleStb == (((k + 1) % n == 0) && tg[0]),
                "R7 strobe", sampleStb, ((k + 1) % n == 0) && tg[0]);
          end
        end
      end
    end

    // R5 change in mid high phase
    startCfg(2, 1'b0);
    for (int k = 0; k <= 13; k++) begin
      @(negedge clk);
      if (k == 2) divReq = RW'(4);
      if (k >= 3) begin
        int e;
        e = (k <= 4) ? 0 : (k <= 8) ? 1 : (k <= 12) ? 0 : 1;
        chk(cardClk == e[0], "R5 reload at low end", cardClk, e);
        chk(sampleStb == (k == 5 || k == 13), "R5 strobe", sampleStb,
            (k == 5 || k == 13));
      end
    end

    // R6 enable low stops clock low next edge
    startCfg(3, 1'b0);
    repeat (4) @(negedge clk);  // k=3: level high
    chk(cardClk == 1'b1, "R6 running high", cardClk, 1);
    clkEn = 1'b0;
    @(negedge clk);
    chk(cardClk == 1'b0, "R6 stopped low", cardClk, 0);
    chk(sampleStb == 1'b0, "R6 stopped stb", sampleStb, 0);
    repeat (5) @(negedge clk);
    chk(cardClk == 1'b0, "R6 stays low", cardClk, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule